// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level short-format translation table that lives in ordinary memory. A requester offers an address on a valid/ready handshake. The walker then picks one of two table base values, using a split control field of three bits. It fetches a first-level descriptor through a word-read port that has a single request in flight at a time. That descriptor either ends the walk or points to a coarse or a fine second-level table. In the second case one more descriptor is read.

A walk finishes with a one-cycle result. The result carries either the physical address or a fault flag, and in both cases it names the table level whose descriptor ended the walk. The walker caches no translations, checks no permissions and decodes no memory attributes. It is meant to sit behind a translation cache and to be started on each miss.

Top module: `ptw_walker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the walker returns to idle. After that edge `req_ready` is 1, `mem_req_valid` is 0 and `done_valid` is 0.
- R2: Let N be `split_n`. If N is nonzero and the top N bits of the address are not all zero, the walk uses `base1`. In every other case it uses `base0`.
- R3: The first read goes to {base[31:14], VA[31:20], 2'b00}.
- R4: A first-level descriptor with bits [1:0] = 2'b10 is a 1 MB section. The result is {desc[31:20], VA[19:0]} at level 1, and the walk makes exactly one read.
- R5: A first-level descriptor with bits [1:0] = 2'b01 selects a coarse table. The second read goes to {desc[31:10], VA[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 2'b11 selects a fine table. The second read goes to {desc[31:12], VA[19:10], 2'b00}.
- R7: A second-level descriptor is decoded by its bits [1:0]:
  - 2'b01 gives {desc[31:16], VA[15:0]}.
  - 2'b10 gives {desc[31:12], VA[11:0]}.
  - 2'b11 gives {desc[31:10], VA[9:0]}.
  
  All three report level 2.
- R8: A descriptor with bits [1:0] = 2'b00 ends the walk with `done_fault` = 1, `done_pa` = 0 and `done_level` set to the level of that descriptor (1 or 2). A first-level fault makes no second read.
- R9: At most one read is in flight. A read request stays asserted with a stable address until `mem_req_ready` accepts it.
- R10: The address, both base values and the split field are captured when a request is accepted. Changing them during the walk does not change that walk's reads or its result.
- R11: `req_ready` is high only while idle, and `done_valid` lasts exactly one cycle. With a memory that accepts at once and answers on the next cycle, `done_valid` appears 3 cycles after the accepting edge for a one-read walk and 5 cycles after it for a two-read walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address to translate |
| base0 | input | 32 | Table base used below the split |
| base1 | input | 32 | Table base used above the split |
| split_n | input | 3 | Split width N; 0 disables `base1` |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| done_valid | output | 1 | One-cycle result strobe |
| done_pa | output | 32 | Physical address (0 on fault) |
| done_fault | output | 1 | Walk ended on an invalid descriptor |
| done_level | output | 2 | Level of the descriptor that ended the walk |

## Verification
The result of a walk is due 3 cycles after the accepting edge when the walk makes one read, and 5 cycles after it when the walk makes two, as long as the memory accepts at once and answers on the next cycle. The bench counts falling edges from acceptance to `done_valid` and compares that count with the latency expected for that read count. It also samples every port on falling edges, so no check depends on process order at the rising edge. Under a stalling, slow memory, only the values and read addresses are compared and latency is not checked.

// File: rtl/ptw_pkg.sv
// Shared types and field positions for the translation table walker.
// Assumes 32-bit addresses and word-aligned descriptors.
package ptw_pkg;
    localparam int ADDR_W       = 32;
    localparam int TBL_LSB      = 14;   // first-level table alignment
    localparam int SECT_LSB     = 20;   // section / first-level index boundary
    localparam int COARSE_LSB   = 10;
    localparam int FINE_LSB     = 12;
    localparam int LARGE_LSB    = 16;
    localparam int SMALL_LSB    = 12;
    localparam int TINY_LSB     = 10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        D1_FAULT   = 2'b00,
        D1_COARSE  = 2'b01,
        D1_SECTION = 2'b10,
        D1_FINE    = 2'b11
    } l1_kind_t;
endpackage

// File: rtl/ptw_base_select.sv
// Chooses the table base for a walk from the split field.
// Assumes SPLIT_W is small enough that the field never exceeds ADDR_W.
module ptw_base_select
    import ptw_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic [ADDR_W-1:0]  va,
    input  logic [ADDR_W-1:0]  base0,
    input  logic [ADDR_W-1:0]  base1,
    input  logic [SPLIT_W-1:0] split,
    output logic [ADDR_W-1:TBL_LSB] base_sel
);
    logic [ADDR_W-1:0] hi_mask;
    logic              use_hi;

    // Mask of the top 'split' address bits, empty when split is zero.
    always_comb begin
        hi_mask = ~({ADDR_W{1'b1}} >> split);
        use_hi  = (split != '0) && ((va & hi_mask) != '0);
        base_sel = use_hi ? base1[ADDR_W-1:TBL_LSB] : base0[ADDR_W-1:TBL_LSB];
    end
endmodule

// File: rtl/ptw_l1_decode.sv
// Decodes a first-level descriptor: kind, section address and
// second-level table word address. Purely combinational.
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output l1_kind_t          kind,
    output logic [ADDR_W-1:0] section_pa,
    output logic [ADDR_W-1:0] l2_addr
);
    // Field extraction and address formation for each table kind.
    always_comb begin
        kind       = l1_kind_t'(desc[1:0]);
        section_pa = {desc[ADDR_W-1:SECT_LSB], va[SECT_LSB-1:0]};
        if (desc[1])
            l2_addr = {desc[ADDR_W-1:FINE_LSB], va[SECT_LSB-1:10], 2'b00};
        else
            l2_addr = {desc[ADDR_W-1:COARSE_LSB], va[SECT_LSB-1:12], 2'b00};
    end
endmodule

// File: rtl/ptw_l2_decode.sv
// Decodes a second-level descriptor into a page address or a fault.
// Purely combinational.
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output logic              fault,
    output logic [ADDR_W-1:0] pa
);
    // Page size select by the descriptor type bits.
    always_comb begin
        fault = (desc[1:0] == 2'b00);
        unique case (desc[1:0])
            2'b01:   pa = {desc[ADDR_W-1:LARGE_LSB], va[LARGE_LSB-1:0]};
            2'b10:   pa = {desc[ADDR_W-1:SMALL_LSB], va[SMALL_LSB-1:0]};
            2'b11:   pa = {desc[ADDR_W-1:TINY_LSB],  va[TINY_LSB-1:0]};
            default: pa = '0;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
// Two-level translation table walker. Accepts one virtual address at a
// time, performs one or two descriptor reads with a single read in flight,
// and reports a physical address or a fault with its level for one cycle.
// Assumes the memory answers every accepted read exactly once.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_va,
    input  logic [ADDR_W-1:0]   base0,
    input  logic [ADDR_W-1:0]   base1,
    input  logic [SPLIT_W-1:0]  split_n,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ADDR_W-1:0]   mem_rsp_data,
    output logic                done_valid,
    output logic [ADDR_W-1:0]   done_pa,
    output logic                done_fault,
    output logic [1:0]          done_level
);
    walk_state_t              state_q;
    logic [ADDR_W-1:0]        va_q;
    logic [ADDR_W-1:TBL_LSB]  base_q;
    logic [ADDR_W-1:0]        l2_addr_q;
    logic [ADDR_W-1:0]        pa_q;
    logic                     fault_q;
    logic [1:0]               level_q;

    logic [ADDR_W-1:TBL_LSB]  base_sel;
    l1_kind_t                 l1_kind;
    logic [ADDR_W-1:0]        l1_section_pa;
    logic [ADDR_W-1:0]        l1_next_addr;
    logic                     l2_fault;
    logic [ADDR_W-1:0]        l2_pa;
    logic [ADDR_W-1:0]        l1_addr;

    ptw_base_select #(.SPLIT_W(SPLIT_W)) u_base (
        .va(req_va), .base0(base0), .base1(base1), .split(split_n),
        .base_sel(base_sel)
    );

    ptw_l1_decode u_l1 (
        .desc(mem_rsp_data), .va(va_q), .kind(l1_kind),
        .section_pa(l1_section_pa), .l2_addr(l1_next_addr)
    );

    ptw_l2_decode u_l2 (
        .desc(mem_rsp_data), .va(va_q), .fault(l2_fault), .pa(l2_pa)
    );

    // First-level descriptor address from captured base and address.
    always_comb l1_addr = {base_q, va_q[ADDR_W-1:SECT_LSB], 2'b00};

    // Walk sequencing and capture of request, descriptor and result data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            va_q      <= '0;
            base_q    <= '0;
            l2_addr_q <= '0;
            pa_q      <= '0;
            fault_q   <= 1'b0;
            level_q   <= 2'd0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    base_q  <= base_sel;
                    state_q <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    unique case (l1_kind)
                        D1_FAULT: begin
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                            level_q <= 2'd1;
                            state_q <= ST_DONE;
                        end
                        D1_SECTION: begin
                            pa_q    <= l1_section_pa;
                            fault_q <= 1'b0;
                            level_q <= 2'd1;
                            state_q <= ST_DONE;
                        end
                        default: begin
                            l2_addr_q <= l1_next_addr;
                            state_q   <= ST_L2_REQ;
                        end
                    endcase
                end
                ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    pa_q    <= l2_fault ? '0 : l2_pa;
                    fault_q <= l2_fault;
                    level_q <= 2'd2;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the walk state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        mem_req_addr  = (state_q == ST_L2_REQ) ? l2_addr_q : l1_addr;
        done_valid    = (state_q == ST_DONE);
        done_pa       = pa_q;
        done_fault    = fault_q;
        done_level    = level_q;
    end
endmodule

// File: rtl/ptw_walker_checks.sv
// Protocol and result-shape properties of the walker, attached by bind.
module ptw_walker_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        done_valid,
    input logic        done_fault,
    input logic [1:0]  done_level,
    input logic [31:0] done_pa
);
    logic inflight;

    // Tracks whether an accepted read still awaits its data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inflight <= 1'b0;
        else if (mem_req_valid && mem_req_ready)
            inflight <= 1'b1;
        else if (mem_rsp_valid)
            inflight <= 1'b0;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_req_valid && !done_valid));

    p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    p_fault_zero_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_pa == 32'd0 &&
                                        (done_level == 2'd1 || done_level == 2'd2)));

    p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !inflight);

    p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !req_ready);
endmodule

bind ptw_walker ptw_walker_checks u_checks (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .done_valid(done_valid), .done_fault(done_fault),
    .done_level(done_level), .done_pa(done_pa)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] base0 = '0;
    logic [31:0] base1 = '0;
    logic [2:0]  split_n = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_pa;
    logic        done_fault;
    logic [1:0]  done_level;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] memw [logic [31:0]];
    logic [31:0] rec_addr [4];
    int          rec_n = 0;
    bit          slow_mode = 1'b0;
    int          cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .base0(base0), .base1(base1), .split_n(split_n),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_pa(done_pa),
        .done_fault(done_fault), .done_level(done_level)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return memw.exists(a) ? memw[a] : 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: decides ready, records accepted reads, answers later.
    initial begin
        bit          pend = 1'b0;
        int          lat = 0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_req_ready = slow_mode ? (cyc % 3 == 0) : 1'b1;
            if (!rst_n) begin
                pend = 1'b0;
            end else if (pend) begin
                mem_req_ready = 1'b0;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(paddr);
                    pend = 1'b0;
                end else lat--;
            end else if (mem_req_valid === 1'b1 && mem_req_ready) begin
                pend  = 1'b1;
                paddr = mem_req_addr;
                lat   = slow_mode ? 3 : 0;
                if (rec_n < 4) rec_addr[rec_n] = mem_req_addr;
                rec_n++;
            end
        end
    end

    // Expected walk outcome computed from the requirements.
    task automatic model(input logic [31:0] va, b0, b1, input logic [2:0] n,
                         output logic [31:0] pa, output logic f, output logic [1:0] lvl,
                         output int nr, output logic [31:0] a1, output logic [31:0] a2);
        logic [31:0] base, d1, d2;
        bit use1;
        use1 = (n != 0) && ((va >> (32 - int'(n))) != 0);
        base = use1 ? b1 : b0;
        a1 = {base[31:14], va[31:20], 2'b00};
        d1 = rd(a1);
        a2 = '0; pa = '0; f = 1'b0; lvl = 2'd1; nr = 1;
        case (d1[1:0])
            2'b00: f = 1'b1;
            2'b10: pa = {d1[31:20], va[19:0]};
            default: begin
                nr = 2; lvl = 2'd2;
                a2 = d1[1] ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
                d2 = rd(a2);
                case (d2[1:0])
                    2'b00: f = 1'b1;
                    2'b01: pa = {d2[31:16], va[15:0]};
                    2'b10: pa = {d2[31:12], va[11:0]};
                    default: pa = {d2[31:10], va[9:0]};
                endcase
            end
        endcase
    endtask

    // One walk; optional disturbance of the captured inputs after acceptance.
    task automatic walk(input string tag, input logic [31:0] va, b0, b1,
                        input logic [2:0] n, input bit disturb);
        logic [31:0] epa, ea1, ea2;
        logic        ef;
        logic [1:0]  elvl;
        int          enr, k;
        model(va, b0, b1, n, epa, ef, elvl, enr, ea1, ea2);
        @(negedge clk);
        chk({tag, " R11 ready when idle"}, {31'd0, req_ready}, 32'd1);
        rec_n = 0;
        req_valid = 1'b1; req_va = va; base0 = b0; base1 = b1; split_n = n;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        if (disturb) begin
            req_va = ~va; base0 = b1 ^ 32'h00FF_C000; base1 = b0 ^ 32'h0F00_0000;
            split_n = ~n;
        end
        while (done_valid !== 1'b1 && k < 80) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " R9 result arrives"}, {31'd0, done_valid}, 32'd1);
        chk({tag, " R4 R7 physical address"}, done_pa, epa);
        chk({tag, " R8 fault flag"}, {31'd0, done_fault}, {31'd0, ef});
        chk({tag, " R8 level"}, {30'd0, done_level}, {30'd0, elvl});
        chk({tag, " R4 R8 read count"}, rec_n, enr);
        chk({tag, " R2 R3 first read address"}, rec_addr[0], ea1);
        if (enr == 2) chk({tag, " R5 R6 second read address"}, rec_addr[1], ea2);
        if (!slow_mode) chk({tag, " R11 latency"}, k, (enr == 1) ? 3 : 5);
        @(negedge clk);
        chk({tag, " R11 done one cycle"}, {31'd0, done_valid}, 32'd0);
    endtask

    // Near-exhaustive sweep over descriptor kinds and addresses.
    task automatic type_sweep(input string tag, input bit disturb);
        logic [31:0] vas [5];
        logic [31:0] l1d [4];
        logic [31:0] b0;
        vas[0] = 32'h0000_0000; vas[1] = 32'h1234_5678; vas[2] = 32'hFFFF_FFFF;
        vas[3] = 32'h8765_4ABC; vas[4] = 32'h000F_F3FF;
        l1d[0] = 32'hFFFF_FFFC; l1d[1] = 32'h0020_07FD;
        l1d[2] = 32'h5A5A_5A5A; l1d[3] = 32'h0030_1FFF;
        b0 = 32'h0001_0000;
        for (int v = 0; v < 5; v++) begin
            for (int t1 = 0; t1 < 4; t1++) begin
                for (int t2 = 0; t2 < 4; t2++) begin
                    logic [31:0] a1, a2;
                    if ((t1 == 0 || t1 == 2) && t2 != 0) continue;
                    memw.delete();
                    a1 = {b0[31:14], vas[v][31:20], 2'b00};
                    memw[a1] = l1d[t1];
                    a2 = l1d[t1][1] ? {l1d[t1][31:12], vas[v][19:10], 2'b00}
                                    : {l1d[t1][31:10], vas[v][19:12], 2'b00};
                    memw[a2] = 32'hC3A5_F6FC | 32'(t2);
                    walk(tag, vas[v], b0, 32'h0004_0000, 3'd0, disturb);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 reset no read", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 reset no result", {31'd0, done_valid}, 32'd0);
        rst_n = 1'b1;

        // Base selection over every split width and addresses at the boundary.
        for (int n = 0; n < 8; n++) begin
            logic [31:0] vs [4];
            vs[0] = 32'h0000_0000; vs[1] = 32'hFFFF_FFFF;
            vs[2] = (n == 0) ? 32'h8000_0000 : (32'h1 << (32 - n));
            vs[3] = (n == 0) ? 32'h7FFF_FFFF : ((32'h1 << (32 - n)) - 1);
            for (int i = 0; i < 4; i++) begin
                memw.delete();
                memw[{18'h0004, vs[i][31:20], 2'b00}] = 32'h1230_0002;
                memw[{18'h0010, vs[i][31:20], 2'b00}] = 32'h4560_0002;
                walk("R2 split sweep", vs[i], 32'h0001_0000, 32'h0004_0000, 3'(n), 1'b0);
            end
        end

        type_sweep("R7 fast", 1'b0);
        slow_mode = 1'b1;
        type_sweep("R9 slow", 1'b0);
        type_sweep("R10 disturbed", 1'b1);
        slow_mode = 1'b0;

        // Reset in the middle of a walk.
        slow_mode = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_va = 32'h1234_5678;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-walk reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 mid-walk reset no read", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 mid-walk reset no result", {31'd0, done_valid}, 32'd0);
        rst_n = 1'b1;
        slow_mode = 1'b0;
        repeat (6) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R9: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule